// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds eight binary tokens that a left and a right port share for software locking. Each port reaches the tokens through its own semaphore-space select. The three low address bits pick a token, and bit 0 of the write data carries the operation. Writing 0 asks for the token and writing 1 gives it up. Every port keeps its own request latch per token. The token goes to whichever side asked first. When the holder lets go while the other side is still asking, the token passes straight across.

A read returns the token state as the reading side sees it, repeated on all eight data bits: 0x00 means this side holds the token, and 0xFF means it does not. The read value is captured when the read starts. It stays frozen while the read is held, so a change made by the other side in mid-read cannot tear it. All logic is synchronous to one clock, with an asynchronous active-low reset.

Top module: `twin_port_semaphore`

## Requirements
- R1: Address bits 2:0 select one of eight independent tokens, and every higher address bit has no effect on a write or a read.
- R2: A port writes only when its chip-enable input is 1, its semaphore-select input is 0 and its write-enable input is 0. Only data bit 0 is used (0 = request, 1 = release), and data bits 7:1 are ignored.
- R3: A read gives 0x00 when the reading side holds the token and 0xFF otherwise. When a free token is requested by one side, that side reads 0x00 and the other side reads 0xFF.
- R4: A request from the side that does not hold the token stays latched for that side and leaves the holder unchanged.
- R5: When the holder releases, a latched request from the other side receives the token at the same clock edge. With nothing pending, the token becomes free and both sides read 0xFF.
- R6: When both sides request a free token at the same clock edge, the left side gets it. A request made at an earlier edge always wins over a later one.
- R7: A read is active while chip enable is 1, semaphore select is 0, output enable is 0 and write enable is 1. At the first edge of an active read, the output register captures the token state from before that edge. It then holds that value until the read goes inactive, and the next active read captures again.
- R8: With chip enable 0 and semaphore select 0 at the same time, the port does nothing: no write happens and no read capture happens.
- R9: After reset, every request latch holds 1, every token is free and both data outputs read 0xFF.
- R10: The two sides never hold the same token at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, must be 1 for semaphore space |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address; bits 2:0 pick the token |
| l_din | input | DATA_W | Left write data; bit 0 used |
| l_dout | output | DATA_W | Left captured read data |
| r_ce_n | input | 1 | Right chip enable, must be 1 for semaphore space |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address; bits 2:0 pick the token |
| r_din | input | DATA_W | Right write data; bit 0 used |
| r_dout | output | DATA_W | Right captured read data |

## Verification
The hardest situation to reach from the ports is a read held open on one side while the other side releases a token. That release hands the token to the reading side's pending request, so the live state changes under a frozen read. A directed sequence sets up this exact sequence: the right side holds, the left side queues a request, the left side opens its read, and then the right side releases. Random traffic is drawn mostly from three tokens, so that same-edge requests, hand-overs and releases by the non-holder occur often. Each random step ends with a read on both sides, which is compared with a reference model kept in the bench.

// File: rtl/twin_port_semaphore.sv
module twin_port_semaphore #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic              l_sem_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              r_ce_n,
  input  logic              r_sem_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] r_dout
);
  localparam int NFLAG = 1 << SEL_W;

  logic             l_sel, l_wr, l_rd, r_sel, r_wr, r_rd;
  logic [SEL_W-1:0] l_idx, r_idx;
  logic [NFLAG-1:0] rq_l, rq_r, own_l, own_r;
  logic [NFLAG-1:0] nrq_l, nrq_r, nown_l, nown_r;
  logic             l_act_q, r_act_q;
  logic [DATA_W-1:0] l_dout_q, r_dout_q;
  logic             unused_bits;

  assign l_sel = l_ce_n & ~l_sem_n;
  assign r_sel = r_ce_n & ~r_sem_n;
  assign l_wr  = l_sel & ~l_we_n;
  assign r_wr  = r_sel & ~r_we_n;
  assign l_rd  = l_sel & l_we_n & ~l_oe_n;
  assign r_rd  = r_sel & r_we_n & ~r_oe_n;
  assign l_idx = l_addr[SEL_W-1:0];
  assign r_idx = r_addr[SEL_W-1:0];

  assign unused_bits = ^{l_addr[ADDR_W-1:SEL_W], r_addr[ADDR_W-1:SEL_W],
                         l_din[DATA_W-1:1], r_din[DATA_W-1:1]};

  always_comb begin
    nrq_l = rq_l;
    if (l_wr) nrq_l[l_idx] = l_din[0];
  end

  always_comb begin
    nrq_r = rq_r;
    if (r_wr) nrq_r[r_idx] = r_din[0];
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign nown_l[g] = ~nrq_l[g] & (~own_r[g] | nrq_r[g]);
    assign nown_r[g] = ~nrq_r[g] & (own_r[g] | nrq_l[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_l  <= '1;
      rq_r  <= '1;
      own_l <= '0;
      own_r <= '0;
    end else begin
      rq_l  <= nrq_l;
      rq_r  <= nrq_r;
      own_l <= nown_l;
      own_r <= nown_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_act_q  <= 1'b0;
      r_act_q  <= 1'b0;
      l_dout_q <= '1;
      r_dout_q <= '1;
    end else begin
      l_act_q <= l_rd;
      r_act_q <= r_rd;
      if (l_rd && !l_act_q) l_dout_q <= {DATA_W{~own_l[l_idx]}};
      if (r_rd && !r_act_q) r_dout_q <= {DATA_W{~own_r[r_idx]}};
    end
  end

  assign l_dout = l_dout_q;
  assign r_dout = r_dout_q;

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0); // R10
  AST_HOLDER_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    ((own_l & rq_l) | (own_r & rq_r)) == '0); // R4
  AST_HANDOFF_TO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(own_l) & ~own_l & ~rq_r & ~own_r) == '0); // R5
  AST_HANDOFF_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(own_r) & ~own_r & ~rq_l & ~own_l) == '0); // R5
  AST_FROZEN_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && l_act_q) |=> $stable(l_dout)); // R7
  AST_FROZEN_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd && r_act_q) |=> $stable(r_dout)); // R7
  AST_BAD_SELECT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_ce_n && !l_sem_n) |=> ($stable(rq_l) && $stable(l_dout))); // R8
  AST_BAD_SELECT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_ce_n && !r_sem_n) |=> ($stable(rq_r) && $stable(r_dout))); // R8
endmodule

// File: tb/sim_twin_port_semaphore.sv
`timescale 1ns/1ps
module sim_twin_port_semaphore;
  logic clk = 1'b0, rst_n = 1'b0;
  logic l_ce_n, l_sem_n, l_we_n, l_oe_n, r_ce_n, r_sem_n, r_we_n, r_oe_n;
  logic [14:0] l_addr, r_addr;
  logic [7:0] l_din, r_din, l_dout, r_dout;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  bit m_rl[8], m_rr[8];
  int m_own[8];

  always #2 clk = ~clk;

  twin_port_semaphore u0 (.clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
    .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout));

  function automatic logic [7:0] exp_rd(input int side, input int f);
    return (m_own[f] == side) ? 8'h00 : 8'hFF;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_step();
    bit nl[8], nr[8];
    nl = m_rl; nr = m_rr;
    if (l_ce_n && !l_sem_n && !l_we_n) nl[l_addr[2:0]] = l_din[0];
    if (r_ce_n && !r_sem_n && !r_we_n) nr[r_addr[2:0]] = r_din[0];
    for (int i = 0; i < 8; i++) begin
      case (m_own[i])
        1: if (nl[i]) m_own[i] = nr[i] ? 0 : 2;
        2: if (nr[i]) m_own[i] = nl[i] ? 0 : 1;
        default: if (!nl[i]) m_own[i] = 1; else if (!nr[i]) m_own[i] = 2;
      endcase
    end
    m_rl = nl; m_rr = nr;
  endfunction

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
  endtask

  task automatic idle_l(); l_ce_n = 1; l_sem_n = 1; l_we_n = 1; l_oe_n = 1; l_addr = 0; l_din = 0; endtask
  task automatic idle_r(); r_ce_n = 1; r_sem_n = 1; r_we_n = 1; r_oe_n = 1; r_addr = 0; r_din = 0; endtask
  task automatic wr_l(input logic [14:0] a, input logic [7:0] d);
    l_ce_n = 1; l_sem_n = 0; l_we_n = 0; l_oe_n = 1; l_addr = a; l_din = d;
  endtask
  task automatic wr_r(input logic [14:0] a, input logic [7:0] d);
    r_ce_n = 1; r_sem_n = 0; r_we_n = 0; r_oe_n = 1; r_addr = a; r_din = d;
  endtask
  task automatic rd_l(input logic [14:0] a); l_ce_n = 1; l_sem_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = a; endtask
  task automatic rd_r(input logic [14:0] a); r_ce_n = 1; r_sem_n = 0; r_we_n = 1; r_oe_n = 0; r_addr = a; endtask

  task automatic rd_both(input string req, input logic [14:0] al, input logic [14:0] ar);
    logic [7:0] el, er;
    el = exp_rd(1, int'(al[2:0]));
    er = exp_rd(2, int'(ar[2:0]));
    rd_l(al); rd_r(ar);
    tick();
    check({req, " left"}, l_dout, el);
    check({req, " right"}, r_dout, er);
    idle_l(); idle_r();
    tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8; i++) begin m_rl[i] = 1; m_rr[i] = 1; m_own[i] = 0; end
    idle_l(); idle_r();
    repeat (3) @(negedge clk);
    check("R9 reset left dout", l_dout, 8'hFF);
    check("R9 reset right dout", r_dout, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    for (int f = 0; f < 8; f++) rd_both("R9 free after reset", 15'(f), 15'(f));

    // R3: free token taken by left, data bits 7:1 ignored (R2)
    wr_l(15'd3, 8'hFE); tick(); idle_l(); tick();
    rd_both("R3 left takes free", 15'd3, 15'd3);
    check("R3 left holds literal", exp_rd(1, 3), 8'h00);
    // R4: right requests while left holds
    wr_r(15'd3, 8'h00); tick(); idle_r(); tick();
    rd_both("R4 right pending", 15'd3, 15'd3);
    // R5: left release hands token to right
    wr_l(15'd3, 8'h01); tick(); idle_l(); tick();
    rd_both("R5 handoff to right", 15'd3, 15'd3);
    check("R5 handoff literal", exp_rd(2, 3), 8'h00);
    wr_r(15'd3, 8'hFF); tick(); idle_r(); tick();
    rd_both("R5 free after release", 15'd3, 15'd3);

    // R6: same-edge requests, left wins
    wr_l(15'd5, 8'h00); wr_r(15'd5, 8'h00); tick(); idle_l(); idle_r(); tick();
    rd_both("R6 tie to left", 15'd5, 15'd5);
    check("R6 tie literal", exp_rd(1, 5), 8'h00);
    wr_l(15'd5, 8'h01); wr_r(15'd5, 8'h01); tick(); idle_l(); idle_r(); tick();
    // R6: earlier request wins
    wr_r(15'd6, 8'h00); tick(); idle_r();
    wr_l(15'd6, 8'h00); tick(); idle_l(); tick();
    rd_both("R6 earlier right wins", 15'd6, 15'd6);
    wr_r(15'd6, 8'h01); tick(); idle_r(); tick();
    rd_both("R5 pending left receives", 15'd6, 15'd6);
    wr_l(15'd6, 8'h01); tick(); idle_l(); tick();

    // R1: upper address bits ignored
    wr_l(15'h7FF9, 8'h00); tick(); idle_l(); tick();
    rd_both("R1 high bits ignored", 15'h0001, 15'h2A31);
    wr_l(15'h4441, 8'h01); tick(); idle_l(); tick();
    rd_both("R1 release via other alias", 15'h0001, 15'h0001);

    // R8: chip enable and semaphore select both low does nothing
    l_ce_n = 0; l_sem_n = 0; l_we_n = 0; l_oe_n = 1; l_addr = 15'd4; l_din = 8'h00;
    tick(); idle_l(); tick();
    rd_both("R8 no write", 15'd4, 15'd4);
    check("R8 no write literal", exp_rd(1, 4), 8'hFF);
    wr_l(15'd2, 8'h00); tick(); idle_l(); tick();
    rd_both("R8 setup", 15'd2, 15'd2);
    l_ce_n = 0; l_sem_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = 15'd7;
    tick();
    check("R8 no read capture", l_dout, 8'h00);
    idle_l(); tick();
    wr_l(15'd2, 8'h01); tick(); idle_l(); tick();

    // R7: frozen read while the token moves to the reader
    wr_r(15'd2, 8'h00); tick(); idle_r();
    wr_l(15'd2, 8'h00); tick(); idle_l(); tick();
    rd_l(15'd2); tick();
    check("R7 capture at read start", l_dout, 8'hFF);
    wr_r(15'd2, 8'h01); tick(); idle_r();
    check("R7 held after handoff", l_dout, 8'hFF);
    tick();
    check("R7 still held", l_dout, 8'hFF);
    idle_l(); tick();
    rd_both("R7 recapture after reopen", 15'd2, 15'd2);
    check("R7 recapture literal", exp_rd(1, 2), 8'h00);
    wr_l(15'd2, 8'h01); tick(); idle_l(); tick();

    // random traffic, biased toward few tokens
    for (int it = 0; it < 1500; it++) begin
      int kl, kr;
      kl = $urandom % 5; kr = $urandom % 5;
      if (kl >= 2) wr_l({12'($urandom), 3'(($urandom % 2) ? $urandom % 3 : $urandom % 8)}, 8'($urandom));
      else if (kl == 1) begin l_ce_n = 0; l_sem_n = 0; l_we_n = 0; l_addr = 15'($urandom); l_din = 8'($urandom); end
      if (kr >= 2) wr_r({12'($urandom), 3'(($urandom % 2) ? $urandom % 3 : $urandom % 8)}, 8'($urandom));
      else if (kr == 1) begin r_ce_n = 0; r_sem_n = 0; r_we_n = 0; r_addr = 15'($urandom); r_din = 8'($urandom); end
      tick(); idle_l(); idle_r();
      rd_both("R3 R4 R5 R6 random", 15'($urandom), 15'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule